// File: doc/BRIEF.md
# Two-Register Host Command Port

This block sits on an 8-bit processor bus as a slave and gives the host access to a drawing co-processor through two addresses. An external address decoder supplies a chip select. One address line picks between the command/status register and the data register. The host writes an opcode to the command register, then writes that opcode's argument bytes one at a time to the data register. The block collects the bytes and hands the finished command, with its arguments, to a back-end. While the command runs, the host polls the status register until the busy bit clears.

Opcodes fall into three groups. Some take a fixed number of argument bytes. The print-string opcode takes bytes until a zero byte. The read-back opcodes produce result bytes: the back-end pushes them into a small buffer, and the host drains the buffer by reading the data register. Each bus access lasts one clock cycle with chip select high. Its side effects take hold on that cycle's rising edge. Read data is valid during the access cycle.

Top module: `hostCmdPort`

## Requirements
- R1: After reset the status byte reads 0x00, the result buffer is empty, and cmdValid and argValid are low.
- R2: addrSel=0 selects the command register on writes and the status register on reads. addrSel=1 selects the data register. The status byte has busy in bit 0, error in bit 1, and zeros in bits 7..2.
- R3: Opcodes 0x10 (cursor move) and 0x11 (ellipse) each take exactly four data bytes. In the cycle after the fourth byte is written, cmdValid pulses for one cycle, cmdOpcode holds the opcode, and cmdArgs holds the bytes in arrival order (first byte in bits 7..0, so a 16-bit X or width sent low byte first lands in bits 15..0 and Y or height lands in bits 31..16). Busy is set in that same cycle.
- R4: Opcode 0x20 (print string) accepts data bytes until a zero byte arrives. Each nonzero byte is echoed on argByte with argValid in the next cycle. The zero byte causes cmdValid (with cmdArgs all zero) and sets busy, and it is not echoed.
- R5: Opcode 0x30 (get cursor) takes no arguments, and cmdValid follows in the cycle after the command write. Opcode 0x31 (get pixel) takes four argument bytes. The back-end pushes result bytes with resValid/resData into a buffer of RES_DEPTH (default 4) entries. Pushes made while the buffer is full are dropped. Data-register reads return the buffered bytes in push order.
- R6: While busy, a doneIn pulse clears busy from the next cycle.
- R7: A command write of any other opcode sets the error bit, produces no cmdValid, and leaves the block idle with busy clear.
- R8: The error bit is set by a data write while no argument collection is in progress (idle or busy), and by a data read while the result buffer is empty. Such a read returns 0x00, and such a write produces no argValid.
- R9: A status read returns the error bit as it stood before the read, then clears it from the next cycle on.
- R10: A command write during argument or string collection abandons the pending command and starts the new one, so earlier argument bytes never appear in cmdArgs. A command write while busy sets the error bit and is otherwise ignored.
- R11: Every argument byte accepted for a fixed-length opcode is echoed on argByte with argValid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Access strobe from the address decoder, one cycle per access |
| addrSel | input | 1 | 0 = command/status, 1 = data |
| wrEn | input | 1 | 1 = write, 0 = read |
| hostWdata | input | 8 | Write data from the host |
| hostRdata | output | 8 | Read data for the current access |
| cmdValid | output | 1 | One-cycle pulse when a command is complete |
| cmdOpcode | output | 8 | Opcode of the completed command |
| cmdArgs | output | 32 | Argument bytes, first byte in bits 7..0 |
| argValid | output | 1 | One-cycle pulse for each accepted argument or string byte |
| argByte | output | 8 | The accepted byte |
| doneIn | input | 1 | Back-end finished the current command |
| resValid | input | 1 | Back-end pushes a result byte |
| resData | input | 8 | Result byte |

## Verification
Some behaviours hold on every cycle and are checked by assertions. A completed command always coincides with busy. doneIn always releases busy. A status read always leaves the error bit clear. Reading an empty buffer always raises the error bit. A command write while busy keeps busy. An unknown opcode leaves the block idle with the error bit set. The result buffer never counts past its depth. Other behaviours only show up in the bench's scenarios against its queue-based model: how arguments are ordered and packed, how strings end, what happens when a command is abandoned mid-argument, the order in which result bytes come back, and which pushes are dropped when the buffer is full.

// File: rtl/hostCmdPkg.sv
package hostCmdPkg;
  localparam int ARG_BYTES = 4;
  localparam int ARG_IDX_W = $clog2(ARG_BYTES);

  localparam logic [7:0] OP_CURSOR_MOVE = 8'h10;
  localparam logic [7:0] OP_ELLIPSE     = 8'h11;
  localparam logic [7:0] OP_PRINT_STR   = 8'h20;
  localparam logic [7:0] OP_GET_CURSOR  = 8'h30;
  localparam logic [7:0] OP_GET_PIXEL   = 8'h31;

  typedef enum logic [1:0] {PS_IDLE, PS_ARGS, PS_STRING, PS_BUSY} portState_t;

  typedef struct packed {
    logic                 known;
    logic                 isString;
    logic [ARG_IDX_W:0]   nArgs;
  } opInfo_t;

  typedef struct packed {
    logic                 opLoad;
    logic                 argStore;
    logic [ARG_IDX_W-1:0] argIdx;
    logic                 argEcho;
    logic                 cmdFire;
    logic                 resPop;
  } ctrlStrobe_t;

  function automatic opInfo_t decodeOp(input logic [7:0] op);
    opInfo_t info;
    info = '0;
    case (op)
      OP_CURSOR_MOVE, OP_ELLIPSE, OP_GET_PIXEL: begin
        info.known = 1'b1;
        info.nArgs = (ARG_IDX_W+1)'(ARG_BYTES);
      end
      OP_GET_CURSOR: info.known = 1'b1;
      OP_PRINT_STR: begin
        info.known    = 1'b1;
        info.isString = 1'b1;
      end
      default: info = '0;
    endcase
    return info;
  endfunction
endpackage

// File: rtl/hostCmdCtrl.sv
module hostCmdCtrl
  import hostCmdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipSel,
  input  logic        addrSel,
  input  logic        wrEn,
  input  logic [7:0]  hostWdata,
  input  logic        doneIn,
  input  logic        resEmpty,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        errFlag
);
  logic cmdWr, dataWr, statRd, dataRd;
  assign cmdWr  = chipSel &  wrEn & ~addrSel;
  assign dataWr = chipSel &  wrEn &  addrSel;
  assign statRd = chipSel & ~wrEn & ~addrSel;
  assign dataRd = chipSel & ~wrEn &  addrSel;

  portState_t           stateQ, stateD;
  logic [ARG_IDX_W:0]   needQ, needD;
  logic [ARG_IDX_W-1:0] idxQ, idxD;
  logic                 errQ, errD;
  opInfo_t              info;

  assign info = decodeOp(hostWdata);

  always_comb begin
    stateD = stateQ;
    needD  = needQ;
    idxD   = idxQ;
    errD   = errQ;
    strobe = '0;
    strobe.argIdx = idxQ;

    if (statRd) errD = 1'b0;

    if (dataRd) begin
      if (resEmpty) errD = 1'b1;
      else          strobe.resPop = 1'b1;
    end

    if (cmdWr) begin
      if (stateQ == PS_BUSY) begin
        errD = 1'b1;
      end else if (!info.known) begin
        errD   = 1'b1;
        stateD = PS_IDLE;
      end else begin
        strobe.opLoad = 1'b1;
        idxD  = '0;
        needD = info.nArgs;
        if (info.isString) begin
          stateD = PS_STRING;
        end else if (info.nArgs == '0) begin
          strobe.cmdFire = 1'b1;
          stateD = PS_BUSY;
        end else begin
          stateD = PS_ARGS;
        end
      end
    end

    if (dataWr) begin
      case (stateQ)
        PS_ARGS: begin
          strobe.argStore = 1'b1;
          strobe.argEcho  = 1'b1;
          idxD = idxQ + 1'b1;
          if ({1'b0, idxQ} == needQ - 1'b1) begin
            strobe.cmdFire = 1'b1;
            stateD = PS_BUSY;
          end
        end
        PS_STRING: begin
          if (hostWdata == 8'h00) begin
            strobe.cmdFire = 1'b1;
            stateD = PS_BUSY;
          end else begin
            strobe.argEcho = 1'b1;
          end
        end
        default: errD = 1'b1;
      endcase
    end

    if (doneIn && stateQ == PS_BUSY) stateD = PS_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PS_IDLE;
      needQ  <= '0;
      idxQ   <= '0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      needQ  <= needD;
      idxQ   <= idxD;
      errQ   <= errD;
    end
  end

  assign busy    = (stateQ == PS_BUSY);
  assign errFlag = errQ;

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && busy) |=> !busy);

  // R8
  empty_read_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && resEmpty) |=> errFlag);

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> !errFlag);

  // R10
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busy && !doneIn) |=> (busy && errFlag));

  // R7
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy && !info.known) |=> (errFlag && !busy));
endmodule

// File: rtl/hostCmdData.sv
module hostCmdData
  import hostCmdPkg::*;
#(
  parameter int RES_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [7:0]             hostWdata,
  input  logic                   addrSel,
  input  logic                   busy,
  input  logic                   errFlag,
  input  logic                   resValid,
  input  logic [7:0]             resData,
  output logic [7:0]             hostRdata,
  output logic                   resEmpty,
  output logic                   cmdValid,
  output logic [7:0]             cmdOpcode,
  output logic [8*ARG_BYTES-1:0] cmdArgs,
  output logic                   argValid,
  output logic [7:0]             argByte
);
  localparam int PTR_W = (RES_DEPTH > 1) ? $clog2(RES_DEPTH) : 1;
  localparam int CNT_W = $clog2(RES_DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RES_DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(RES_DEPTH - 1);

  logic [7:0]       resMem [RES_DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] resCnt;
  logic             pushOk;

  assign pushOk   = resValid && (resCnt < CNT_FULL);
  assign resEmpty = (resCnt == '0);

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      resCnt <= '0;
    end else begin
      if (pushOk)        wrPtr <= stepPtr(wrPtr);
      if (strobe.resPop) rdPtr <= stepPtr(rdPtr);
      case ({pushOk, strobe.resPop})
        2'b10:   resCnt <= resCnt + 1'b1;
        2'b01:   resCnt <= resCnt - 1'b1;
        default: resCnt <= resCnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) resMem[wrPtr] <= resData;
  end

  for (genvar g = 0; g < ARG_BYTES; g++) begin : gArg
    logic [7:0] argReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        argReg <= '0;
      else if (strobe.opLoad)
        argReg <= '0;
      else if (strobe.argStore && strobe.argIdx == ARG_IDX_W'(g))
        argReg <= hostWdata;
    end
    assign cmdArgs[8*g +: 8] = argReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOpcode <= '0;
      cmdValid  <= 1'b0;
      argValid  <= 1'b0;
      argByte   <= '0;
    end else begin
      if (strobe.opLoad)  cmdOpcode <= hostWdata;
      cmdValid <= strobe.cmdFire;
      argValid <= strobe.argEcho;
      if (strobe.argEcho) argByte <= hostWdata;
    end
  end

  always_comb begin
    if (addrSel) hostRdata = resEmpty ? 8'h00 : resMem[rdPtr];
    else         hostRdata = {6'b0, errFlag, busy};
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    resCnt <= CNT_FULL);

  // R3
  fire_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy);
endmodule

// File: rtl/hostCmdPort.sv
module hostCmdPort
  import hostCmdPkg::*;
#(
  parameter int RES_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   chipSel,
  input  logic                   addrSel,
  input  logic                   wrEn,
  input  logic [7:0]             hostWdata,
  output logic [7:0]             hostRdata,
  output logic                   cmdValid,
  output logic [7:0]             cmdOpcode,
  output logic [8*ARG_BYTES-1:0] cmdArgs,
  output logic                   argValid,
  output logic [7:0]             argByte,
  input  logic                   doneIn,
  input  logic                   resValid,
  input  logic [7:0]             resData
);
  ctrlStrobe_t strobe;
  logic busy, errFlag, resEmpty;

  hostCmdCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .addrSel(addrSel), .wrEn(wrEn),
    .hostWdata(hostWdata), .doneIn(doneIn), .resEmpty(resEmpty),
    .strobe(strobe), .busy(busy), .errFlag(errFlag)
  );

  hostCmdData #(.RES_DEPTH(RES_DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWdata(hostWdata),
    .addrSel(addrSel), .busy(busy), .errFlag(errFlag),
    .resValid(resValid), .resData(resData), .hostRdata(hostRdata),
    .resEmpty(resEmpty), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .cmdArgs(cmdArgs), .argValid(argValid), .argByte(argByte)
  );
endmodule

// File: tb/test_hostCmdPort.sv
module test_hostCmdPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, addrSel = 1'b0, wrEn = 1'b0;
  logic [7:0] hostWdata = '0;
  logic doneIn = 1'b0, resValid = 1'b0;
  logic [7:0] resData = '0;
  logic [7:0] hostRdata, cmdOpcode, argByte;
  logic [31:0] cmdArgs;
  logic cmdValid, argValid;

  always #2 clk = ~clk;

  hostCmdPort i_hostCmdPort (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .addrSel(addrSel), .wrEn(wrEn),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .cmdValid(cmdValid),
    .cmdOpcode(cmdOpcode), .cmdArgs(cmdArgs), .argValid(argValid),
    .argByte(argByte), .doneIn(doneIn), .resValid(resValid), .resData(resData)
  );

  int nChecks = 0;
  int nFail = 0;

  // reference model state
  int mState = 0;           // 0 idle, 1 args, 2 string, 3 busy
  int mNeed = 0;
  int mIdx = 0;
  bit mErr = 0;
  logic [7:0] mRes[$];
  logic [7:0] mArgs[4];
  logic [7:0] mOp = '0;
  bit eCmdValid = 0, eArgValid = 0;
  logic [7:0] eArgByte = '0, eOp = '0;
  logic [31:0] eArgs = '0;
  logic [7:0] lastRd = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int argsFor(input logic [7:0] op);
    if (op == 8'h10 || op == 8'h11 || op == 8'h31) return 4;
    if (op == 8'h30) return 0;
    if (op == 8'h20) return 99;
    return -1;
  endfunction

  task automatic tick();
    int preSize;
    int preState;
    int n;
    bit nCmdV;
    bit nArgV;
    logic [7:0] expRd;
    #1;
    if (!rstN) begin
      mState = 0; mNeed = 0; mIdx = 0; mErr = 0; mRes.delete();
      for (int i = 0; i < 4; i++) mArgs[i] = '0;
      eCmdValid = 0; eArgValid = 0;
    end else begin
      chk(cmdValid === eCmdValid, "R3 cmdValid", {31'b0, cmdValid}, {31'b0, eCmdValid});
      if (eCmdValid) begin
        chk(cmdOpcode === eOp, "R3 opcode", {24'b0, cmdOpcode}, {24'b0, eOp});
        chk(cmdArgs === eArgs, "R3 args", cmdArgs, eArgs);
      end
      chk(argValid === eArgValid, "R11 argValid", {31'b0, argValid}, {31'b0, eArgValid});
      if (eArgValid)
        chk(argByte === eArgByte, "R4 argByte", {24'b0, argByte}, {24'b0, eArgByte});
      if (chipSel && !wrEn) begin
        if (addrSel) expRd = (mRes.size() > 0) ? mRes[0] : 8'h00;
        else         expRd = {6'b0, mErr, (mState == 3)};
        lastRd = hostRdata;
        chk(hostRdata === expRd, addrSel ? "R5 data read" : "R2 status read",
            {24'b0, hostRdata}, {24'b0, expRd});
      end
      preSize = mRes.size();
      preState = mState;
      nCmdV = 0; nArgV = 0;
      if (chipSel) begin
        if (wrEn && !addrSel) begin
          if (preState == 3) mErr = 1;
          else begin
            n = argsFor(hostWdata);
            if (n < 0) begin mErr = 1; mState = 0; end
            else begin
              mOp = hostWdata; mIdx = 0;
              for (int i = 0; i < 4; i++) mArgs[i] = '0;
              if (n == 99) mState = 2;
              else if (n == 0) begin nCmdV = 1; mState = 3; end
              else begin mState = 1; mNeed = n; end
            end
          end
        end else if (wrEn && addrSel) begin
          if (preState == 1) begin
            nArgV = 1; eArgByte = hostWdata;
            mArgs[mIdx] = hostWdata; mIdx++;
            if (mIdx == mNeed) begin nCmdV = 1; mState = 3; end
          end else if (preState == 2) begin
            if (hostWdata == 8'h00) begin nCmdV = 1; mState = 3; end
            else begin nArgV = 1; eArgByte = hostWdata; end
          end else mErr = 1;
        end else if (!addrSel) begin
          mErr = 0;
        end else begin
          if (preSize == 0) mErr = 1;
          else void'(mRes.pop_front());
        end
      end
      if (doneIn && preState == 3) mState = 0;
      if (resValid && preSize < 4) mRes.push_back(resData);
      eCmdValid = nCmdV;
      eArgValid = nArgV;
      if (nCmdV) begin
        eOp = mOp;
        eArgs = {mArgs[3], mArgs[2], mArgs[1], mArgs[0]};
      end
    end
    @(negedge clk);
  endtask

  task automatic setIn(input bit cs, input bit a, input bit w, input logic [7:0] d,
                       input bit dn, input bit rv, input logic [7:0] rd);
    chipSel = cs; addrSel = a; wrEn = w; hostWdata = d;
    doneIn = dn; resValid = rv; resData = rd;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) setIn(0, 0, 0, 8'h00, 0, 0, 8'h00);
  endtask
  task automatic wrCmd(input logic [7:0] d);  setIn(1, 0, 1, d, 0, 0, 8'h00); endtask
  task automatic wrData(input logic [7:0] d); setIn(1, 1, 1, d, 0, 0, 8'h00); endtask
  task automatic rdStat();                    setIn(1, 0, 0, 8'h00, 0, 0, 8'h00); endtask
  task automatic rdData();                    setIn(1, 1, 0, 8'h00, 0, 0, 8'h00); endtask
  task automatic beDone();                    setIn(0, 0, 0, 8'h00, 1, 0, 8'h00); endtask
  task automatic bePush(input logic [7:0] d); setIn(0, 0, 0, 8'h00, 0, 1, d); endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1: status after reset
    rdStat();
    chk(lastRd == 8'h00, "R1 reset status", {24'b0, lastRd}, 32'h0);
    // R8: empty data read returns 0 and flags error
    rdData();
    chk(lastRd == 8'h00, "R8 empty read", {24'b0, lastRd}, 32'h0);
    // R9: status shows error, then clears
    rdStat();
    chk(lastRd == 8'h02, "R9 error seen", {24'b0, lastRd}, 32'h2);
    rdStat();
    chk(lastRd == 8'h00, "R9 error cleared", {24'b0, lastRd}, 32'h0);

    // R3, R11: cursor move with X=0x1234, Y=0x5678
    wrCmd(8'h10);
    wrData(8'h34); wrData(8'h12); wrData(8'h78); wrData(8'h56);
    idle(1);
    rdStat();
    chk(lastRd == 8'h01, "R2 busy bit", {24'b0, lastRd}, 32'h1);
    // R8: data write while busy
    wrData(8'hAA);
    // R10: command write while busy is ignored
    wrCmd(8'h11);
    rdStat();
    chk(lastRd == 8'h03, "R10 busy+error", {24'b0, lastRd}, 32'h3);
    // R6: done releases busy
    beDone();
    rdStat();
    chk(lastRd == 8'h00, "R6 busy cleared", {24'b0, lastRd}, 32'h0);

    // R10: ellipse abandoned after two bytes by a new cursor move
    wrCmd(8'h11);
    wrData(8'hDE); wrData(8'hAD);
    wrCmd(8'h10);
    wrData(8'h01); wrData(8'h02); wrData(8'h03); wrData(8'h04);
    idle(2); beDone(); idle(1);

    // R3: ellipse with interleaved idle cycles
    wrCmd(8'h11);
    wrData(8'h20); idle(2); wrData(8'h00); wrData(8'h10); idle(1); wrData(8'h00);
    beDone(); idle(1);

    // R4: print string "Hi" then terminator
    wrCmd(8'h20);
    wrData(8'h48); wrData(8'h69); wrData(8'h00);
    idle(1);
    rdStat();
    chk(lastRd == 8'h01, "R4 busy after terminator", {24'b0, lastRd}, 32'h1);
    beDone(); idle(1);

    // R10: string abandoned by a get-cursor command
    wrCmd(8'h20);
    wrData(8'h41);
    wrCmd(8'h30);
    // R5: back-end returns four bytes
    bePush(8'h34); bePush(8'h12); bePush(8'h78); bePush(8'h56);
    beDone();
    rdData(); chk(lastRd == 8'h34, "R5 first result", {24'b0, lastRd}, 32'h34);
    rdData(); rdData(); rdData();
    chk(lastRd == 8'h56, "R5 last result", {24'b0, lastRd}, 32'h56);
    rdData(); // R8: buffer now empty
    rdStat();
    chk(lastRd == 8'h02, "R8 error after drain", {24'b0, lastRd}, 32'h2);

    // R5: get pixel with four args, one result byte
    wrCmd(8'h31);
    wrData(8'h05); wrData(8'h00); wrData(8'h07); wrData(8'h00);
    bePush(8'hC3); beDone();
    rdData(); chk(lastRd == 8'hC3, "R5 pixel", {24'b0, lastRd}, 32'hC3);

    // R7: unknown opcode
    wrCmd(8'h7E);
    idle(1);
    rdStat();
    chk(lastRd == 8'h02, "R7 unknown opcode", {24'b0, lastRd}, 32'h2);
    // R7: unknown opcode during collection abandons it
    wrCmd(8'h10); wrData(8'h11); wrCmd(8'hFF); wrData(8'h22);
    rdStat(); rdStat();

    // R5: overflow drops pushes beyond depth
    for (int i = 0; i < 6; i++) bePush(8'h60 + 8'(i));
    for (int i = 0; i < 5; i++) rdData();
    chk(lastRd == 8'h00, "R5 overflow dropped", {24'b0, lastRd}, 32'h0);
    rdStat();
    idle(2);

    summary();
    $finish;
  end
endmodule